// File: doc/BRIEF.md
# Pending-Bitmap Set/Clear Engine

This block applies single-bit updates to a bitmap of pending interrupts stored in a local byte-wide RAM. A request names a 32-bit interrupt identifier and says whether its bit is to be set or cleared. The engine fetches the byte that holds that bit, works out the new byte, and writes it back only if the bit actually changes. It then raises a one-cycle pulse so that the logic which picks the highest-priority pending interrupt can evaluate again.

The bitmap covers identifiers 0 up to and including 2^(ID_BITS+1). A request with a larger identifier is dropped at once and makes no RAM access. The engine handles one request at a time. While `busy` is high, `req_valid` is not sampled. The RAM is outside the block and returns read data one cycle after a read enable.

Top module: `lpi_pend_engine`

## Requirements
- R1: A request whose identifier is greater than 2^(ID_BITS+1) (256 at the default ID_BITS=7) is discarded. `busy` stays low, and no read, write or re-evaluate pulse follows. An identifier equal to that limit is accepted.
- R2: The RAM byte address is the identifier shifted right by 3. The bit within the byte is the identifier's low 3 bits, with bit 0 as the least significant bit. Reads and writes of one request use the same address.
- R3: A set request (`req_set`=1) whose bit is clear writes back the byte read, with that bit ORed in.
- R4: A clear request (`req_set`=0) whose bit is set writes back the byte read, ANDed with the complement of that bit.
- R5: A set request whose bit is already set performs the read but no write and no re-evaluate pulse. `busy` is high for 2 cycles.
- R6: A clear request whose bit is already clear performs the read but no write and no re-evaluate pulse.
- R7: The cycle after a request is accepted, `mem_rd_en` is high for one cycle. Read data is taken the cycle after that. When the bit changes, `mem_wr_en` is high in the following cycle.
- R8: `reeval` pulses for exactly one cycle, in the cycle right after each write, and at no other time.
- R9: `busy` is high from the cycle after acceptance until the engine returns to idle: 4 cycles when the bit changes, 2 when it does not. A request held on the inputs while `busy` is high has no effect.
- R10: While reset is asserted, `busy`, `reeval`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; sampled only while idle |
| req_id | input | 32 | Interrupt identifier |
| req_set | input | 1 | 1 = set pending bit, 0 = clear it |
| busy | output | 1 | Request in progress |
| reeval | output | 1 | One-cycle pulse after the bitmap changed |
| mem_rd_en | output | 1 | RAM read enable |
| mem_rd_addr | output | ADDR_W | RAM read byte address |
| mem_rd_data | input | 8 | RAM read data, one cycle after read enable |
| mem_wr_en | output | 1 | RAM write enable |
| mem_wr_addr | output | ADDR_W | RAM write byte address |
| mem_wr_data | output | 8 | RAM write data |

## Verification
The engine is driven with sets and clears that change a bit in a byte that already holds other set bits. This shows whether the neighbouring bits survive the merge. Repeated sets and clears of the same bit show whether a redundant update is told apart from a real one, both by write traffic and by the length of `busy`. Identifiers at the limit, one above it and far above it separate accepted from rejected requests. A request held on the inputs during `busy` and then issued properly shows whether anything was sampled while the engine was busy.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_CMP    = 3'd2,
    ST_WRITE  = 3'd3,
    ST_NOTIFY = 3'd4
  } eng_state_e;

  function automatic int unsigned bitmap_bytes(input int unsigned id_bits);
    return ((32'd1 << (id_bits + 1)) / 8) + 1;
  endfunction

endpackage

// File: rtl/lpi_pend_decode.sv
module lpi_pend_decode #(
  parameter int ID_BITS = 7,
  parameter int ADDR_W  = 6
) (
  input  logic [31:0]       id,
  output logic              in_range,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        bit_mask
);
  localparam logic [32:0] ID_LIMIT = 33'd1 << (ID_BITS + 1);

  // Identifiers up to and including the limit are valid
  assign in_range  = ({1'b0, id} <= ID_LIMIT);
  assign byte_addr = id[ADDR_W+2:3];

  for (genvar b = 0; b < 8; b++) begin : g_mask
    assign bit_mask[b] = (id[2:0] == 3'(b));
  end
endmodule

// File: rtl/lpi_pend_merge.sv
module lpi_pend_merge (
  input  logic [7:0] cur_byte,
  input  logic [7:0] bit_mask,
  input  logic       do_set,
  output logic [7:0] new_byte,
  output logic       changed
);
  for (genvar b = 0; b < 8; b++) begin : g_bit
    always_comb begin
      if (bit_mask[b]) new_byte[b] = do_set;
      else             new_byte[b] = cur_byte[b];
    end
  end

  assign changed = |((cur_byte ^ new_byte) & bit_mask);
endmodule

// File: rtl/lpi_pend_fsm.sv
module lpi_pend_fsm
  import lpi_pend_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       changed,
  output logic       accept,
  output eng_state_e state
);
  eng_state_e state_nxt;

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:   if (start) state_nxt = ST_READ;
      ST_READ:   state_nxt = ST_CMP;
      ST_CMP:    state_nxt = changed ? ST_WRITE : ST_IDLE;
      ST_WRITE:  state_nxt = ST_NOTIFY;
      ST_NOTIFY: state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/lpi_pend_engine.sv
module lpi_pend_engine
  import lpi_pend_pkg::*;
#(
  parameter int ID_BITS = 7,
  localparam int NUM_BYTES = bitmap_bytes(ID_BITS),
  localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_id,
  input  logic              req_set,
  output logic              busy,
  output logic              reeval,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  logic              in_range;
  logic [ADDR_W-1:0] dec_addr;
  logic [7:0]        dec_mask;
  logic              accept;
  eng_state_e        state;
  logic [7:0]        merged;
  logic              changed;

  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [7:0]        mask_q, mask_nxt;
  logic              set_q, set_nxt;
  logic [7:0]        wdata_q, wdata_nxt;
  logic              cmp_changed;

  lpi_pend_decode #(.ID_BITS(ID_BITS), .ADDR_W(ADDR_W)) u_decode (
    .id        (req_id),
    .in_range  (in_range),
    .byte_addr (dec_addr),
    .bit_mask  (dec_mask)
  );

  lpi_pend_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_valid && in_range),
    .changed (cmp_changed),
    .accept  (accept),
    .state   (state)
  );

  lpi_pend_merge u_merge (
    .cur_byte (mem_rd_data),
    .bit_mask (mask_q),
    .do_set   (set_q),
    .new_byte (merged),
    .changed  (changed)
  );

  // read data is meaningful only in the compare state
  assign cmp_changed = changed && (state == ST_CMP);

  always_comb begin
    addr_nxt  = addr_q;
    mask_nxt  = mask_q;
    set_nxt   = set_q;
    wdata_nxt = wdata_q;
    if (accept) begin
      addr_nxt = dec_addr;
      mask_nxt = dec_mask;
      set_nxt  = req_set;
    end
    if (cmp_changed) wdata_nxt = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      mask_q  <= '0;
      set_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_nxt;
      mask_q  <= mask_nxt;
      set_q   <= set_nxt;
      wdata_q <= wdata_nxt;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign mem_rd_en   = (state == ST_READ);
  assign mem_rd_addr = addr_q;
  assign mem_wr_en   = (state == ST_WRITE);
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = wdata_q;
  assign reeval      = (state == ST_NOTIFY);
endmodule

// File: rtl/lpi_pend_engine_chk.sv
module lpi_pend_engine_chk #(
  parameter int ID_BITS = 7,
  parameter int ADDR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [31:0]       req_id,
  input logic              busy,
  input logic              reeval,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [7:0]        mem_rd_data,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [7:0]        mem_wr_data
);
  localparam logic [32:0] ID_LIMIT = 33'd1 << (ID_BITS + 1);

  // R1
  reject_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && ({1'b0, req_id} > ID_LIMIT)) |=> (!busy && !mem_rd_en));

  // R7
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && ({1'b0, req_id} <= ID_LIMIT)) |=>
      (mem_rd_en && busy && (mem_rd_addr == $past(req_id[ADDR_W+2:3]))));

  // R3
  single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wr_data ^ $past(mem_rd_data)) == 1));

  // R2
  write_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_addr == $past(mem_rd_addr, 2)));

  // R8
  reeval_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> reeval);

  // R8
  reeval_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reeval |-> ($past(mem_wr_en) && !mem_wr_en));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en && !reeval));

  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (busy && !mem_rd_en));
endmodule

bind lpi_pend_engine lpi_pend_engine_chk #(.ID_BITS(ID_BITS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_id      (req_id),
  .busy        (busy),
  .reeval      (reeval),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_data (mem_rd_data),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data)
);

// File: tb/lpi_pend_engine_test.sv
module lpi_pend_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int ID_BITS    = 7;
  localparam int LIMIT      = 1 << (ID_BITS + 1);
  localparam int NB         = LIMIT / 8 + 1;
  localparam int AW         = $clog2(NB);

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [31:0]   req_id;
  logic          req_set;
  logic          busy, reeval, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]    mem_rd_data, mem_wr_data;

  logic [7:0] ram    [NB];
  logic [7:0] shadow [NB];

  typedef struct {
    int         addr;
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  int rd_count = 0;
  bit reeval_due = 0;

  lpi_pend_engine #(.ID_BITS(ID_BITS)) uut (
    .clk, .rst_n, .req_valid, .req_id, .req_set, .busy, .reeval,
    .mem_rd_en, .mem_rd_addr, .mem_rd_data, .mem_wr_en, .mem_wr_addr, .mem_wr_data
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model, one cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= ram[mem_rd_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected writes, checks re-evaluate pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (reeval_due) begin
        check(reeval == 1'b1, "R8", "reeval after write", int'(reeval), 1);
        reeval_due = 0;
      end else if (reeval) begin
        check(1'b0, "R8", "reeval without write", 1, 0);
      end
      if (mem_rd_en) rd_count++;
      if (mem_wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected write", int'(mem_wr_addr), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(mem_wr_addr) == e.addr, "R2", "write address", int'(mem_wr_addr), e.addr);
          check(mem_wr_data == e.data, e.tag, "write data", int'(mem_wr_data), int'(e.data));
        end
        reeval_due = 1;
      end
    end
  end

  task automatic issue(input logic [31:0] id, input bit set, input string tag,
                       input bit hold);
    int rd0;
    int n;
    bit ok_range;
    int a;
    logic [7:0] oldb, newb;
    rd0 = rd_count;
    ok_range = ({1'b0, id} <= 33'(LIMIT));
    a = 0; newb = 8'h00; oldb = 8'h00;
    if (ok_range) begin
      a = int'(id >> 3);
      oldb = shadow[a];
      newb = set ? (oldb | (8'h01 << id[2:0])) : (oldb & ~(8'h01 << id[2:0]));
      if (newb != oldb) exp_q.push_back('{a, newb, tag});
      shadow[a] = newb;
    end
    req_valid = 1'b1; req_id = id; req_set = set;
    @(posedge clk); #2;
    if (!hold) req_valid = 1'b0;
    if (!ok_range) begin
      check(busy == 1'b0, "R1", "busy on rejected id", int'(busy), 0);
      repeat (3) @(posedge clk);
      #2;
      check(rd_count == rd0, "R1", "reads on rejected id", rd_count - rd0, 0);
      return;
    end
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    check(mem_rd_en == 1'b1, "R7", "read enable after accept", int'(mem_rd_en), 1);
    check(int'(mem_rd_addr) == a, "R2", "read address", int'(mem_rd_addr), a);
    if (hold) begin
      req_id = 32'd200; req_set = 1'b1;
    end
    n = 1;
    while (busy && n < 20) begin
      @(posedge clk); #2;
      if (busy) n++;
      if (hold && n == 3) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    check(n == ((newb != oldb) ? 4 : 2), tag, "busy length", n, (newb != oldb) ? 4 : 2);
    check(rd_count - rd0 == 1, "R7", "read count", rd_count - rd0, 1);
    @(posedge clk); #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      ram[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_set = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check(!busy && !reeval && !mem_rd_en && !mem_wr_en, "R10", "outputs in reset",
          int'({busy, reeval, mem_rd_en, mem_wr_en}), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    issue(32'd5,   1'b1, "R3", 1'b0);  // byte0 -> 0x20
    issue(32'd5,   1'b1, "R5", 1'b0);  // redundant set
    issue(32'd3,   1'b1, "R3", 1'b0);  // byte0 -> 0x28, neighbour kept
    issue(32'd5,   1'b0, "R4", 1'b0);  // byte0 -> 0x08
    issue(32'd5,   1'b0, "R6", 1'b0);  // redundant clear
    issue(32'd100, 1'b0, "R6", 1'b0);  // clear of never-set bit
    issue(32'd256, 1'b1, "R1", 1'b0);  // limit accepted, byte 32
    issue(32'd257, 1'b1, "R1", 1'b0);  // just above limit
    issue(32'hFFFF_FFFF, 1'b1, "R1", 1'b0);
    issue(32'h8000_0000, 1'b0, "R1", 1'b0);
    issue(32'd255, 1'b1, "R3", 1'b0);  // byte 31 bit 7
    // R9: request for id 200 held during busy must be ignored
    issue(32'd64,  1'b1, "R3", 1'b1);
    issue(32'd200, 1'b1, "R9", 1'b0);  // must still write (bit was clear)
    for (int k = 80; k < 88; k++) issue(32'(k), 1'b1, "R3", 1'b0);
    for (int k = 80; k < 88; k += 2) issue(32'(k), 1'b0, "R4", 1'b0);
    issue(32'd81,  1'b1, "R5", 1'b0);

    repeat (4) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R8", "pending expected writes", exp_q.size(), 0);
    for (int i = 0; i < NB; i++)
      check(ram[i] == shadow[i], "R3", $sformatf("bitmap byte %0d", i),
            int'(ram[i]), int'(shadow[i]));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule